// File: doc/BRIEF.md
# Serial DAC Host Driver

This block sits on the host side of a three-wire link to a voltage-output DAC. A requester presents one request at a time. The request is either a code write, which carries a 12-bit value, or a mode command, which carries a 2-bit operating mode. The block turns the request into a 16-bit command word and shifts it out most significant bit first. It drives an active-low select, a serial clock that idles low, and a data line. All link timing comes from the system clock, and each analog timing limit is converted to a whole number of system cycles.

After the block sends a wake command, it blocks code writes for a recovery interval so the converter can settle. Mode commands are still accepted during that interval. The requester holds `reqValid` until `reqAccept` is high in a cycle. `busy` covers the time from acceptance until the frame ends. `done` pulses once when the select line has been high for its minimum time after the frame.

Top module: `dac_link_host`

## Requirements
- R1: After reset, csN=1, sclk=0, sdo=0, busy=0, done=0, wakeHold=0 and reqAccept=0 while reqValid=0.
- R2: A code write (reqIsWrite=1) sends the word {4'b0000, reqArg[11:0]}, 16 bits, MSB first. A receiver sampling on each falling sclk edge sees the word in order.
- R3: A mode command (reqIsWrite=0) sends {4'b1111, ten zero bits, reqArg[1:0]}. The modes are 00 wake, 01 output floating, 10 1k to ground and 11 100k to ground. reqArg[11:2] does not affect the word.
- R4: After csN falls, sclk stays low for exactly ceil(T_CSS_NS/period) cycles, and then it rises for the first bit.
- R5: Each sclk high phase and each low phase between bits lasts exactly ceil(T_HALF_NS/period) cycles. sdo changes only together with a falling sclk edge, so it is stable during every high phase.
- R6: Each frame has exactly 16 sclk pulses. csN rises exactly ceil(T_CSH_NS/period) cycles after the last falling edge, with sclk low.
- R7: Between frames, csN stays high for at least ceil(T_CSW_NS/period) cycles. done is a single-cycle pulse issued after that interval, and busy is low in the done cycle.
- R8: A request is accepted only while busy is low. A request presented while busy is high is not accepted and does not alter or add a frame.
- R9: When a wake frame ends, wakeHold is high, and no code-write frame begins within ceil(T_WAKE_NS/period) cycles of that frame's csN rise.
- R10: A mode command presented while wakeHold is high and busy is low is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until accepted |
| reqIsWrite | input | 1 | 1 = code write, 0 = mode command |
| reqArg | input | 12 | Code for a write; bits [1:0] give the mode for a mode command |
| reqAccept | output | 1 | Request taken in this cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame and the select-high gap are complete |
| wakeHold | output | 1 | Wake recovery running; code writes are held off |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the DAC |

## Verification
Directed words exercise the word builder: all-zero, all-one and alternating codes, plus every power-down mode with junk in the ignored argument bits. A wrong bit order or a leaked argument bit shows up as a word mismatch. A run-length monitor measures every select and clock phase, so an off-by-one in any phase counter is caught separately from a data error. Wake sequences followed at once by a code write, and by a power-down, show whether the recovery hold applies only to writes. A request pushed during a busy frame confirms that such a request is refused. Seeded random mixes of writes and modes, wake included, then repeat the same checks on arbitrary sequences.

// File: rtl/dac_link_pkg.sv
package dac_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP
  } linkState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic frameStart;
    logic clkRise;
    logic clkFall;
    logic frameEnd;
  } linkStrobe_t;

  localparam int CMD_W = 4;
  localparam int MODE_W = 2;
  localparam logic [CMD_W-1:0] CMD_CODE = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_MODE = 4'b1111;
  localparam logic [MODE_W-1:0] MODE_WAKE = 2'b00;

  function automatic int cyclesFor(input int ns, input int periodPs);
    int c;
    c = (ns * 1000 + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/dac_link_ctrl.sv
module dac_link_ctrl
  import dac_link_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SETUP_CYC = 2,
  parameter int HALF_CYC = 3,
  parameter int HOLD_CYC = 1,
  parameter int GAP_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsWrite,
  input  logic        wakeHold,
  output linkStrobe_t strobe,
  output logic        reqAccept,
  output logic        busy,
  output logic        done
);

  localparam int MAX_A = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int MAX_B = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_CYC + 1);
  localparam int BIT_W = $clog2(WORD_W);

  linkState_t state, stateNxt;
  logic [TMR_W-1:0] tmr, tmrVal;
  logic tmrLoad, tmrZero, doneSet;
  logic [BIT_W-1:0] bitCnt;

  assign tmrZero = (tmr == '0);
  assign busy = (state != ST_IDLE);

  always_comb begin
    stateNxt = state;
    tmrLoad = 1'b0;
    tmrVal = '0;
    strobe = '0;
    doneSet = 1'b0;
    reqAccept = reqValid && (state == ST_IDLE) && !(reqIsWrite && wakeHold);
    case (state)
      ST_IDLE: if (reqAccept) begin
        strobe.frameStart = 1'b1;
        stateNxt = ST_LEAD;
        tmrLoad = 1'b1;
        tmrVal = TMR_W'(SETUP_CYC - 1);
      end
      ST_LEAD: if (tmrZero) begin
        strobe.clkRise = 1'b1;
        stateNxt = ST_HIGH;
        tmrLoad = 1'b1;
        tmrVal = TMR_W'(HALF_CYC - 1);
      end
      ST_HIGH: if (tmrZero) begin
        strobe.clkFall = 1'b1;
        tmrLoad = 1'b1;
        if (bitCnt == BIT_W'(WORD_W - 1)) begin
          stateNxt = ST_TAIL;
          tmrVal = TMR_W'(HOLD_CYC - 1);
        end else begin
          stateNxt = ST_LOW;
          tmrVal = TMR_W'(HALF_CYC - 1);
        end
      end
      ST_LOW: if (tmrZero) begin
        strobe.clkRise = 1'b1;
        stateNxt = ST_HIGH;
        tmrLoad = 1'b1;
        tmrVal = TMR_W'(HALF_CYC - 1);
      end
      ST_TAIL: if (tmrZero) begin
        strobe.frameEnd = 1'b1;
        stateNxt = ST_GAP;
        tmrLoad = 1'b1;
        tmrVal = TMR_W'(GAP_CYC - 1);
      end
      ST_GAP: if (tmrZero) begin
        doneSet = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tmr <= '0;
      bitCnt <= '0;
      done <= 1'b0;
    end else begin
      state <= stateNxt;
      done <= doneSet;
      if (tmrLoad) tmr <= tmrVal;
      else if (!tmrZero) tmr <= tmr - 1'b1;
      if (strobe.frameStart) bitCnt <= '0;
      else if (strobe.clkFall) bitCnt <= bitCnt + 1'b1;
    end
  end

  // R8: an accepted request always opens a frame
  a_r8_accept_opens_frame: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> busy);

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: done only follows the select-high gap
  a_r7_done_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state) == ST_GAP);

endmodule

// File: rtl/dac_link_dp.sv
module dac_link_dp
  import dac_link_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int WAKE_CYC = 800
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobe_t       strobe,
  input  logic              reqIsWrite,
  input  logic [DATA_W-1:0] reqArg,
  output logic              csN,
  output logic              sclk,
  output logic              sdo,
  output logic              wakeHold
);

  localparam int WORD_W = DATA_W + CMD_W;
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  logic [WORD_W-1:0] word, shReg;
  logic wakeFrame;
  logic [WAKE_W-1:0] wakeCnt;

  always_comb begin
    if (reqIsWrite) word = {CMD_CODE, reqArg};
    else word = {CMD_MODE, {(DATA_W - MODE_W){1'b0}}, reqArg[MODE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN <= 1'b1;
      sclk <= 1'b0;
      sdo <= 1'b0;
      shReg <= '0;
      wakeFrame <= 1'b0;
    end else begin
      if (strobe.frameStart) begin
        csN <= 1'b0;
        sdo <= word[WORD_W-1];
        shReg <= word << 1;
        wakeFrame <= !reqIsWrite && (reqArg[MODE_W-1:0] == MODE_WAKE);
      end
      if (strobe.clkRise) sclk <= 1'b1;
      if (strobe.clkFall) begin
        sclk <= 1'b0;
        sdo <= shReg[WORD_W-1];
        shReg <= shReg << 1;
      end
      if (strobe.frameEnd) csN <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wakeCnt <= '0;
    else if (strobe.frameEnd && wakeFrame) wakeCnt <= WAKE_W'(WAKE_CYC);
    else if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
  end

  assign wakeHold = (wakeCnt != '0);

  // R5: data holds still while the clock is high
  a_r5_sdo_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R4: clock pulses only inside a frame
  a_r4_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  // R6: select rises with the clock already low
  a_r6_cs_rise_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (!sclk && !$past(sclk)));

  // R9: the control never opens a write frame during recovery
  a_r9_no_write_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameStart && reqIsWrite) |-> (wakeCnt == '0));

endmodule

// File: rtl/dac_link_host.sv
module dac_link_host
  import dac_link_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CLK_PS = 10000,
  parameter int T_HALF_NS = 25,
  parameter int T_CSS_NS = 15,
  parameter int T_CSH_NS = 10,
  parameter int T_CSW_NS = 80,
  parameter int T_WAKE_NS = 8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [DATA_W-1:0] reqArg,
  output logic              reqAccept,
  output logic              busy,
  output logic              done,
  output logic              wakeHold,
  output logic              csN,
  output logic              sclk,
  output logic              sdo
);

  localparam int WORD_W = DATA_W + CMD_W;
  localparam int HALF_CYC = cyclesFor(T_HALF_NS, CLK_PS);
  localparam int SETUP_CYC = cyclesFor(T_CSS_NS, CLK_PS);
  localparam int HOLD_CYC = cyclesFor(T_CSH_NS, CLK_PS);
  localparam int GAP_CYC = cyclesFor(T_CSW_NS, CLK_PS);
  localparam int WAKE_CYC = cyclesFor(T_WAKE_NS, CLK_PS);

  linkStrobe_t strobe;

  dac_link_ctrl #(
    .WORD_W(WORD_W), .SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC),
    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .wakeHold(wakeHold), .strobe(strobe), .reqAccept(reqAccept),
    .busy(busy), .done(done)
  );

  dac_link_dp #(
    .DATA_W(DATA_W), .WAKE_CYC(WAKE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIsWrite(reqIsWrite),
    .reqArg(reqArg), .csN(csN), .sclk(sclk), .sdo(sdo), .wakeHold(wakeHold)
  );

endmodule

// File: tb/dac_link_host_bench.sv
module dac_link_host_bench;

  localparam int CLK_NS = 10;
  localparam int CLK_PS = CLK_NS * 1000;
  localparam int HALF_C = (25 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CSS_C = (15 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CSH_C = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CSW_C = (80 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WAKE_C = (8000 * 1000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqIsWrite = 1'b0;
  logic [11:0] reqArg = '0;
  logic reqAccept, busy, done, wakeHold, csN, sclk, sdo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  dac_link_host #(.DATA_W(12), .CLK_PS(CLK_PS)) u_dac_link_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqArg(reqArg), .reqAccept(reqAccept), .busy(busy), .done(done),
    .wakeHold(wakeHold), .csN(csN), .sclk(sclk), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(input bit isWr, input logic [11:0] arg);
    return isWr ? {4'h0, arg} : {4'hF, 10'h000, arg[1:0]};
  endfunction

  // link monitor
  logic [15:0] expW = '0;
  int frames = 0;
  longint cyc = 0;
  logic prevCs = 1'b1, prevSclk = 1'b0, prevSdo = 1'b0;
  int runLen = 0;
  int nBits = 0;
  logic [15:0] got = '0;
  bit sdoMoved = 1'b0;
  bit haveWake = 1'b0;
  longint wakeRiseCyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevSclk && sclk && sdo != prevSdo) sdoMoved = 1'b1;
      if (csN != prevCs || sclk != prevSclk) begin
        if (prevCs && !csN) begin
          if (frames > 0) chk(runLen >= CSW_C, "R7", "cs high gap", runLen, CSW_C);
          if (haveWake && expW[15:12] == 4'h0)
            chk(cyc - wakeRiseCyc > WAKE_C, "R9", "write after wake gap",
                cyc - wakeRiseCyc, WAKE_C);
          nBits = 0; got = '0; sdoMoved = 1'b0;
        end else if (!prevCs && !prevSclk && sclk) begin
          if (nBits == 0) chk(runLen == CSS_C, "R4", "cs to first rise", runLen, CSS_C);
          else if (runLen != HALF_C) chk(0, "R5", "low phase", runLen, HALF_C);
          got = {got[14:0], sdo};
          nBits++;
        end else if (!prevCs && prevSclk && !sclk) begin
          if (runLen != HALF_C) chk(0, "R5", "high phase", runLen, HALF_C);
        end else if (!prevCs && csN) begin
          chk(runLen == CSH_C, "R6", "last fall to cs rise", runLen, CSH_C);
          chk(nBits == 16, "R6", "pulses per frame", nBits, 16);
          chk(got == expW, expW[15] ? "R3" : "R2", "word", got, expW);
          chk(!sdoMoved, "R5", "sdo moved while high", sdoMoved, 0);
          if (expW[15:12] == 4'hF && expW[1:0] == 2'b00) begin
            haveWake = 1'b1; wakeRiseCyc = cyc;
          end
          frames++;
        end
        runLen = 1;
      end else runLen++;
    end
    prevCs = csN; prevSclk = sclk; prevSdo = sdo;
  end

  // returns cycles waited before acceptance
  task automatic sendReq(input bit isWr, input logic [11:0] arg, output int waited);
    waited = 0;
    @(negedge clk);
    expW = mkWord(isWr, arg);
    reqValid = 1'b1; reqIsWrite = isWr; reqArg = arg;
    #1;
    while (!reqAccept) begin
      @(negedge clk); #1; waited++;
    end
    @(negedge clk);
    reqValid = 1'b0;
    reqArg = 12'h5A5;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk); #1; n++;
    end
    chk(done, "R7", "done seen", done, 1);
    chk(!busy, "R7", "busy low with done", busy, 0);
    @(negedge clk); #1;
    chk(!done, "R7", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    int f0;
    logic [31:0] r;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    #1;
    chk(csN == 1'b1, "R1", "reset csN", csN, 1);
    chk(sclk == 1'b0 && sdo == 1'b0, "R1", "reset sclk/sdo", {sclk, sdo}, 0);
    chk(!busy && !done && !wakeHold && !reqAccept, "R1", "reset status",
        {busy, done, wakeHold, reqAccept}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 directed codes
    sendReq(1, 12'hA5C, w); waitDone();
    sendReq(1, 12'h000, w); waitDone();
    sendReq(1, 12'hFFF, w); waitDone();
    sendReq(1, 12'h555, w); waitDone();

    // R3 power-down modes with junk in ignored bits
    sendReq(0, 12'hFFD, w); waitDone();
    sendReq(0, 12'hAAE, w); waitDone();
    sendReq(0, 12'h3C3, w); waitDone();

    // R8 request while busy is refused and leaves the frame alone
    sendReq(1, 12'h9C1, w);
    f0 = frames;
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = 1'b0; reqArg = 12'h003;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (reqAccept) chk(0, "R8", "accepted while busy", reqAccept, 0);
      @(negedge clk);
    end
    chk(busy, "R8", "still busy during push", busy, 1);
    reqValid = 1'b0;
    waitDone();
    repeat (30) @(negedge clk);
    chk(frames == f0 + 1, "R8", "frame count", frames, f0 + 1);

    // R9 wake then immediate write
    sendReq(0, 12'hF00, w); waitDone();
    chk(wakeHold, "R9", "hold after wake", wakeHold, 1);
    sendReq(1, 12'h7E1, w);
    chk(w >= WAKE_C - CSW_C - 2, "R9", "write waited", w, WAKE_C - CSW_C - 2);
    waitDone();

    // R10 power-down during recovery goes at once
    sendReq(0, 12'h000, w); waitDone();
    sendReq(0, 12'h002, w);
    chk(w == 0, "R10", "pd accept latency", w, 0);
    chk(wakeHold, "R10", "recovery still running", wakeHold, 1);
    waitDone();

    // seeded random mix
    for (int k = 0; k < 30; k++) begin
      r = $urandom;
      if (r[2:0] == 3'd0) sendReq(0, {r[13:4], 2'b00}, w);
      else if (r[2:0] < 3'd3) sendReq(0, r[15:4], w);
      else sendReq(1, r[27:16], w);
      waitDone();
    end

    repeat (20) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule